// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This unit performs the architectural side of taking an exception and of returning from one. A request names a cause, a 2-bit subcause (used by the program cause) and an error word. In one clock the unit picks the address to save (the faulting instruction or the next one) and builds the saved status word. It forms the new machine-state word and the handler address, then redirects the program counter. The unit owns the single save pair: save register 0 holds the return address and save register 1 holds the saved status.

A return request reloads the program counter and machine state from that save pair. The program counter is word-aligned and the status bits are masked. The core supplies its current program counter and machine-state word. It also supplies a flattened table of per-cause handler offsets and a prefix word. Every result is registered and appears one cycle after the request, marked by a one-cycle completion pulse.

Top module: `trap_unit`

## Requirements
- R1: After reset the save pair, `pc_o`, `msr_o` and `halted_o` are all zero, and `done_o`, `fault_o`, `redirect_o` and `save_we_o` are low.
- R2: On an entry, save register 1 receives `cur_msr_i` with the bits of mask 0x783F0000 cleared, ORed with the cause's reason bits. The instruction-storage cause (code 3) ORs in the whole `req_err_i` word.
- R3: The alignment (5), floating-point-unavailable (7) and vector-unavailable (12) causes save `cur_pc_i - 4` in save register 0. The program cause (6) also saves `cur_pc_i - 4`, except a floating-point program exception whose two exception-mode bits (bit 11 and bit 8) are equal, which saves `cur_pc_i`. Every other cause saves `cur_pc_i`.
- R4: Program subcause encoding 0 = floating-point enabled, 1 = illegal, 2 = privileged, 3 = trap. Their reason bits are 0x00100000, 0x00080000, 0x00040000 and 0x00020000. Subcause 0 also sets 0x00010000 when its two mode bits differ.
- R5: A floating-point program request is dropped when both mode bits (11, 8) are zero or the floating-point enable bit 13 is zero. In that case only `done_o` pulses, and all other outputs keep their values.
- R6: The new machine state has only two bits that can be set. Bit 12 (machine-check enable) is copied from `cur_msr_i`, but is forced to zero for the machine-check cause (1). Bit 0 (little-endian) equals bit 16 (interrupt little-endian) of `cur_msr_i`.
- R7: A machine-check entry taken while `cur_msr_i` bit 12 is zero sets `halted_o`, which stays set until reset.
- R8: On an entry, `pc_o` becomes the table entry of the cause (bits `cause*32 +: 32` of `vec_table_i`) ORed with `prefix_i`.
- R9: A cause whose table entry is all ones is undefined. Its request pulses `fault_o` with `done_o` and changes no other output.
- R10: A return loads `pc_o` from save register 0 with bits 1:0 cleared, and `msr_o` from save register 1 ANDed with the complement of 0x783F0000. The save pair is left unchanged.
- R11: Each result appears on the clock edge that samples the request, and `done_o` pulses for that one cycle. When `req_valid_i` and `rfi_valid_i` are high together, the entry is taken and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Exception entry request |
| req_cause_i | input | 4 | Cause code |
| req_sub_i | input | 2 | Program subcause |
| req_err_i | input | 32 | Error word |
| rfi_valid_i | input | 1 | Return-from-interrupt request |
| cur_pc_i | input | 32 | Current program counter |
| cur_msr_i | input | 32 | Current machine-state word |
| vec_table_i | input | 512 | Handler offsets, 32 bits per cause |
| prefix_i | input | 32 | Handler prefix word |
| srr0_o | output | 32 | Save register 0 (return address) |
| srr1_o | output | 32 | Save register 1 (saved status) |
| pc_o | output | 32 | Next program counter |
| msr_o | output | 32 | Next machine-state word |
| redirect_o | output | 1 | `pc_o`/`msr_o` updated this cycle |
| save_we_o | output | 1 | Save pair written this cycle |
| done_o | output | 1 | Request completed |
| fault_o | output | 1 | Undefined vector |
| halted_o | output | 1 | Checkstop (sticky) |

## Verification
Every result of this unit is registered once. Values driven before a rising edge are therefore due on the outputs just after that same edge. The bench drives on the falling edge and compares one time unit after the next rising edge. It then holds a cycle with no request to confirm that the completion and redirect strobes fall back and the state holds. Because the save pair persists, the bench keeps its own copy of it. A return is checked against what the bench's model recorded at the last accepted entry, not against values read back from the design.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned CAUSE_W = 4;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [CAUSE_W-1:0] cause_t;

  typedef enum logic [CAUSE_W-1:0] {
    CS_CRIT  = 4'd0,  CS_MCHK  = 4'd1,  CS_DSTOR = 4'd2,  CS_ISTOR = 4'd3,
    CS_EXT   = 4'd4,  CS_ALIGN = 4'd5,  CS_PROG  = 4'd6,  CS_FPUN  = 4'd7,
    CS_SCALL = 4'd8,  CS_DEC   = 4'd9,  CS_FIXT  = 4'd10, CS_WDOG  = 4'd11,
    CS_VECUN = 4'd12, CS_TRACE = 4'd13, CS_SPR0  = 4'd14, CS_SPR1  = 4'd15
  } cause_e;

  typedef enum logic [1:0] {
    PS_FP = 2'd0, PS_ILL = 2'd1, PS_PRIV = 2'd2, PS_TRAP = 2'd3
  } prog_sub_e;

  localparam int BIT_LE  = 0;
  localparam int BIT_FE1 = 8;
  localparam int BIT_FE0 = 11;
  localparam int BIT_ME  = 12;
  localparam int BIT_FP  = 13;
  localparam int BIT_ILE = 16;

  localparam word_t SAVE_CLEAR = 32'h783F_0000;
  localparam word_t RSN_FPE    = 32'h0010_0000;
  localparam word_t RSN_FPPREC = 32'h0001_0000;
  localparam word_t RSN_ILL    = 32'h0008_0000;
  localparam word_t RSN_PRIV   = 32'h0004_0000;
  localparam word_t RSN_TRAP   = 32'h0002_0000;

  function automatic logic fp_modes_differ(word_t m);
    return m[BIT_FE0] ^ m[BIT_FE1];
  endfunction

  function automatic logic fp_drop(cause_t c, logic [1:0] s, word_t m);
    logic no_mode;
    no_mode = ~(m[BIT_FE0] | m[BIT_FE1]);
    return (c == CS_PROG) && (s == PS_FP) && (no_mode || !m[BIT_FP]);
  endfunction

  function automatic word_t reason_bits(cause_t c, logic [1:0] s, word_t e, word_t m);
    word_t r;
    r = '0;
    if (c == CS_ISTOR) r = e;
    else if (c == CS_PROG) begin
      unique case (s)
        PS_FP:   r = RSN_FPE | (fp_modes_differ(m) ? RSN_FPPREC : '0);
        PS_ILL:  r = RSN_ILL;
        PS_PRIV: r = RSN_PRIV;
        default: r = RSN_TRAP;
      endcase
    end
    return r;
  endfunction

  function automatic logic saves_fault_addr(cause_t c, logic [1:0] s, word_t m);
    logic r;
    unique case (c)
      CS_ALIGN, CS_FPUN, CS_VECUN: r = 1'b1;
      CS_PROG: r = (s != PS_FP) || fp_modes_differ(m);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic word_t entry_msr(cause_t c, word_t m);
    word_t r;
    r = '0;
    r[BIT_ME] = m[BIT_ME] & (c != CS_MCHK);
    r[BIT_LE] = m[BIT_ILE];
    return r;
  endfunction

  function automatic word_t rfi_pc(word_t s0);
    return {s0[WORD_W-1:2], 2'b00};
  endfunction

  function automatic word_t rfi_msr(word_t s1);
    return s1 & ~SAVE_CLEAR;
  endfunction
endpackage

// File: rtl/trap_status_calc.sv
module trap_status_calc
  import trap_pkg::*;
(
  input  cause_t      cause_i,
  input  logic [1:0]  sub_i,
  input  word_t       err_i,
  input  word_t       pc_i,
  input  word_t       msr_i,
  output word_t       save_pc_o,
  output word_t       save_msr_o,
  output word_t       new_msr_o,
  output logic        drop_o,
  output logic        chkstop_o
);
  logic use_fault;

  always_comb begin
    use_fault  = saves_fault_addr(cause_i, sub_i, msr_i);
    save_pc_o  = use_fault ? (pc_i - word_t'(4)) : pc_i;
    save_msr_o = (msr_i & ~SAVE_CLEAR) | reason_bits(cause_i, sub_i, err_i, msr_i);
    new_msr_o  = entry_msr(cause_i, msr_i);
    drop_o     = fp_drop(cause_i, sub_i, msr_i);
    chkstop_o  = (cause_i == CS_MCHK) && !msr_i[BIT_ME];
  end
endmodule

// File: rtl/trap_vector_sel.sv
module trap_vector_sel
  import trap_pkg::*;
#(
  parameter int unsigned N_VEC = 16
) (
  input  logic [N_VEC*WORD_W-1:0] table_i,
  input  word_t                   prefix_i,
  input  cause_t                  cause_i,
  output word_t                   target_o,
  output logic                    undef_o
);
  localparam int unsigned N_SLOT = 1 << CAUSE_W;

  word_t slot [N_SLOT];

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    if (g < N_VEC) begin : g_have
      assign slot[g] = table_i[g*WORD_W +: WORD_W];
    end else begin : g_none
      assign slot[g] = '1;
    end
  end

  word_t entry;
  always_comb begin
    entry    = slot[cause_i];
    undef_o  = &entry;
    target_o = entry | prefix_i;
  end
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int unsigned N_VEC = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid_i,
  input  logic [3:0]              req_cause_i,
  input  logic [1:0]              req_sub_i,
  input  logic [31:0]             req_err_i,
  input  logic                    rfi_valid_i,
  input  logic [31:0]             cur_pc_i,
  input  logic [31:0]             cur_msr_i,
  input  logic [N_VEC*32-1:0]     vec_table_i,
  input  logic [31:0]             prefix_i,
  output logic [31:0]             srr0_o,
  output logic [31:0]             srr1_o,
  output logic [31:0]             pc_o,
  output logic [31:0]             msr_o,
  output logic                    redirect_o,
  output logic                    save_we_o,
  output logic                    done_o,
  output logic                    fault_o,
  output logic                    halted_o
);
  word_t save_pc, save_msr, new_msr, target;
  logic  drop, chkstop, undef;

  trap_status_calc u_status (
    .cause_i    (req_cause_i),
    .sub_i      (req_sub_i),
    .err_i      (req_err_i),
    .pc_i       (cur_pc_i),
    .msr_i      (cur_msr_i),
    .save_pc_o  (save_pc),
    .save_msr_o (save_msr),
    .new_msr_o  (new_msr),
    .drop_o     (drop),
    .chkstop_o  (chkstop)
  );

  trap_vector_sel #(.N_VEC(N_VEC)) u_vec (
    .table_i  (vec_table_i),
    .prefix_i (prefix_i),
    .cause_i  (req_cause_i),
    .target_o (target),
    .undef_o  (undef)
  );

  // named events, shared with the checker
  logic take_entry, take_rfi, take_fault, req_drop;
  assign req_drop   = req_valid_i & drop;
  assign take_fault = req_valid_i & ~drop & undef;
  assign take_entry = req_valid_i & ~drop & ~undef;
  assign take_rfi   = rfi_valid_i & ~req_valid_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srr0_o     <= '0;
      srr1_o     <= '0;
      pc_o       <= '0;
      msr_o      <= '0;
      redirect_o <= 1'b0;
      save_we_o  <= 1'b0;
      done_o     <= 1'b0;
      fault_o    <= 1'b0;
      halted_o   <= 1'b0;
    end else begin
      done_o     <= req_valid_i | rfi_valid_i;
      fault_o    <= take_fault;
      redirect_o <= take_entry | take_rfi;
      save_we_o  <= take_entry;
      if (take_entry) begin
        srr0_o <= save_pc;
        srr1_o <= save_msr;
        pc_o   <= target;
        msr_o  <= new_msr;
        if (chkstop) halted_o <= 1'b1;
      end else if (take_rfi) begin
        pc_o  <= rfi_pc(srr0_o);
        msr_o <= rfi_msr(srr1_o);
      end
    end
  end
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid_i,
  input logic        rfi_valid_i,
  input logic [3:0]  req_cause_i,
  input logic        take_entry,
  input logic        take_rfi,
  input logic        take_fault,
  input logic        req_drop,
  input logic [31:0] srr0_o,
  input logic [31:0] srr1_o,
  input logic [31:0] pc_o,
  input logic [31:0] msr_o,
  input logic        redirect_o,
  input logic        save_we_o,
  input logic        done_o,
  input logic        fault_o,
  input logic        halted_o
);
  p_rfi_shape_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take_rfi |=> (pc_o[1:0] == 2'b00) && ((msr_o & 32'h783F_0000) == 32'h0)
                 && $stable(srr0_o) && $stable(srr1_o));

  p_entry_msr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_entry |=> ((msr_o & ~32'h0000_1001) == 32'h0) && save_we_o);

  p_mchk_me_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_entry && req_cause_i == 4'd1) |=> !msr_o[12]);

  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> halted_o);

  p_fault_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_fault |=> fault_o && !redirect_o && !save_we_o
                   && $stable(pc_o) && $stable(srr0_o));

  p_drop_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_drop |=> done_o && !redirect_o && !fault_o && $stable(msr_o) && $stable(srr1_o));

  p_done_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(req_valid_i || rfi_valid_i));

  p_redirect_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> done_o);
endmodule

bind trap_unit trap_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid_i (req_valid_i),
  .rfi_valid_i (rfi_valid_i),
  .req_cause_i (req_cause_i),
  .take_entry  (take_entry),
  .take_rfi    (take_rfi),
  .take_fault  (take_fault),
  .req_drop    (req_drop),
  .srr0_o      (srr0_o),
  .srr1_o      (srr1_o),
  .pc_o        (pc_o),
  .msr_o       (msr_o),
  .redirect_o  (redirect_o),
  .save_we_o   (save_we_o),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .halted_o    (halted_o)
);

// File: tb/trap_unit_tb.sv
`timescale 1ns/1ps
module trap_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [3:0]  req_cause_i = '0;
  logic [1:0]  req_sub_i = '0;
  logic [31:0] req_err_i = '0;
  logic        rfi_valid_i = 1'b0;
  logic [31:0] cur_pc_i = '0;
  logic [31:0] cur_msr_i = '0;
  logic [16*32-1:0] vec_table_i;
  logic [31:0] prefix_i = '0;
  logic [31:0] srr0_o, srr1_o, pc_o, msr_o;
  logic        redirect_o, save_we_o, done_o, fault_o, halted_o;

  logic [31:0] tbl [16];
  always_comb for (int i = 0; i < 16; i++) vec_table_i[i*32 +: 32] = tbl[i];

  always #2 clk = ~clk;

  trap_unit u_dut (.*);

  int checks = 0;
  int errors = 0;
  logic [31:0] e_srr0 = 0, e_srr1 = 0, e_pc = 0, e_msr = 0;
  logic        e_halt = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request cycle followed by checks after the sampling edge
  task automatic step(bit rq, bit rf, int c, int s, logic [31:0] err,
                      logic [31:0] pc, logic [31:0] m, string tag);
    bit dropit, undef, e_done, e_fault, e_redir, e_we;
    logic [31:0] rsn;
    @(negedge clk);
    req_valid_i = rq; rfi_valid_i = rf; req_cause_i = 4'(c); req_sub_i = 2'(s);
    req_err_i = err; cur_pc_i = pc; cur_msr_i = m;
    e_done = rq | rf; e_fault = 0; e_redir = 0; e_we = 0;
    if (rq) begin
      dropit = (c == 6) && (s == 0) && ((m[11] == 0 && m[8] == 0) || m[13] == 0);
      undef  = (tbl[c] == 32'hFFFF_FFFF);
      if (!dropit && undef) e_fault = 1;
      else if (!dropit) begin
        e_redir = 1; e_we = 1;
        rsn = 0;
        if (c == 3) rsn = err;
        if (c == 6) case (s)
          0: rsn = 32'h0010_0000 | ((m[11] != m[8]) ? 32'h0001_0000 : 0);
          1: rsn = 32'h0008_0000;
          2: rsn = 32'h0004_0000;
          default: rsn = 32'h0002_0000;
        endcase
        e_srr1 = (m & 32'h87C0_FFFF) | rsn;
        if (c == 5 || c == 7 || c == 12 || (c == 6 && !(s == 0 && m[11] == m[8])))
          e_srr0 = pc - 4;
        else e_srr0 = pc;
        e_msr = 0;
        e_msr[0]  = m[16];
        e_msr[12] = m[12] && (c != 1);
        e_pc = tbl[c] | prefix_i;
        if (c == 1 && !m[12]) e_halt = 1;
      end
    end else if (rf) begin
      e_redir = 1;
      e_pc  = e_srr0 & 32'hFFFF_FFFC;
      e_msr = e_srr1 & 32'h87C0_FFFF;
    end
    @(posedge clk); #1;
    chk({tag, " R11 done"}, 32'(done_o), 32'(e_done));
    chk({tag, " R9 fault"}, 32'(fault_o), 32'(e_fault));
    chk({tag, " R11 redirect"}, 32'(redirect_o), 32'(e_redir));
    chk({tag, " R2 save_we"}, 32'(save_we_o), 32'(e_we));
    chk({tag, " R3 srr0"}, srr0_o, e_srr0);
    chk({tag, " R2 srr1"}, srr1_o, e_srr1);
    chk({tag, " R8 pc"}, pc_o, e_pc);
    chk({tag, " R6 msr"}, msr_o, e_msr);
    chk({tag, " R7 halted"}, 32'(halted_o), 32'(e_halt));
    req_valid_i = 0; rfi_valid_i = 0;
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, cur_pc_i, cur_msr_i, tag);
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [31:0] FPON = 32'h0000_2000;

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) tbl[i] = (i * 32'h100) & 32'h0000_FFF0;
    tbl[14] = 32'hFFFF_FFFF;
    prefix_i = 32'hFFF0_0000;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset srr0", srr0_o, 0);
    chk("R1 reset msr", msr_o, 0);
    chk("R1 reset pc", pc_o, 0);
    chk("R1 reset strobes", {28'b0, done_o, fault_o, redirect_o, save_we_o}, 0);
    chk("R1 reset halted", 32'(halted_o), 0);
    @(negedge clk); rst_n = 1;

    // R3 alignment saves pc-4; R6 ILE copied to LE, ME kept
    step(1, 0, 5, 0, 0, 32'h0000_2000, 32'h0001_1000, "R3 align");
    idle("R11 idle after align");
    // R10 return
    step(0, 1, 0, 0, 0, 32'h0, 32'h0, "R10 rfi");
    // R4 program subcauses
    step(1, 0, 6, 1, 0, 32'h0000_4000, 32'hFFFF_FFFF, "R4 illegal");
    step(1, 0, 6, 2, 0, 32'h0000_4004, 32'h0000_0000, "R4 priv");
    step(1, 0, 6, 3, 0, 32'h0000_4008, 32'h0000_1000, "R4 trap");
    // R4/R3 FP precise and imprecise
    step(1, 0, 6, 0, 0, 32'h0000_5000, FPON | 32'h0000_0800, "R4 fp precise");
    step(1, 0, 6, 0, 0, 32'h0000_5010, FPON | 32'h0000_0900, "R3 fp imprecise");
    // R5 drops
    step(1, 0, 6, 0, 0, 32'h0000_6000, FPON, "R5 drop modes zero");
    step(1, 0, 6, 0, 0, 32'h0000_6000, 32'h0000_0800, "R5 drop fp off");
    // R2 instruction storage ORs error word
    step(1, 0, 3, 0, 32'h4000_0000, 32'h0000_7000, 32'h783F_1234, "R2 istor");
    // R9 undefined vector
    step(1, 0, 14, 0, 0, 32'h0000_8000, 32'h0, "R9 undefined");
    // R11 entry wins over return
    step(1, 1, 9, 0, 0, 32'h0000_9003, 32'h0000_1000, "R11 both");
    // R6 machine check with ME set: clears ME, no halt
    step(1, 0, 1, 0, 0, 32'h0000_A000, 32'h0001_1000, "R6 mchk me");
    step(0, 1, 0, 0, 0, 32'h0, 32'h0, "R10 rfi2");
    // random mix
    for (int n = 0; n < 400; n++) begin
      int c, s, r;
      r = int'($urandom_range(0, 9));
      c = int'($urandom_range(0, 15));
      if (c == 1 && $urandom_range(0, 3) != 0) c = 2;
      s = int'($urandom_range(0, 3));
      if (r == 0) idle("R11 rnd idle");
      else if (r == 1) step(0, 1, 0, 0, 0, $urandom, $urandom, "R10 rnd rfi");
      else step(1, $urandom_range(0, 1), c, s, $urandom, $urandom,
                $urandom | ((c == 1) ? 32'h0000_1000 : 32'h0), "R2 rnd entry");
    end
    // R7 checkstop, then stickiness
    step(1, 0, 1, 0, 0, 32'h0000_B000, 32'h0, "R7 checkstop");
    idle("R7 sticky");
    step(1, 0, 4, 0, 0, 32'h0000_C000, 32'h0000_1000, "R7 sticky after entry");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule